// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Block with Divisor Latch

This block is a register-mapped asynchronous serial port. Software reaches it through eight byte-wide offsets using single-cycle read and write strobes. Through these offsets it sets the bit rate, the line format, the FIFO trigger level and the modem-control lines. It sends bytes by writing them and receives bytes by reading them. Transmit and receive each use a 16-entry FIFO. The line format is fixed at 8 data bits, no parity and 1 stop bit, sent least significant bit first.

Bit 7 of the line-control byte switches offsets 0 and 1 from the data path and interrupt-enable byte to the two halves of a 16-bit divisor. The divisor divides a 16x-oversampling reference tick that runs at 16 times 115200 baud. That tick is derived from the system clock by `CLKS_PER_TICK`. A divisor of 3 therefore gives 38400 baud. The receiver samples at 16 times the bit rate, confirms a start bit at mid-bit and drops bytes with a bad stop bit. A level-triggered interrupt output tells software when enough bytes are waiting.

Top module: `uart_regif`

## Requirements
- R1: After reset the line status byte (offset 5) reads 0x60, and the line-control, interrupt-enable, modem-control and scratch bytes read 0. The divisor reads 1, `txd` is 1, and `dtr`, `rts` and `irq` are 0.
- R2: While line-control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte, and an offset-0 write queues nothing for transmission. While it is 0, offset 1 holds the interrupt-enable byte in bits 3:0.
- R3: One bit lasts exactly 16 × divisor × `CLKS_PER_TICK` clocks. A frame is one 0 start bit, 8 data bits LSB first and one 1 stop bit. The line rests at 1.
- R4: A write to offset 0 with bit 7 of line control clear queues the byte in a 16-entry transmit FIFO. Line status bit 5 is 1 when that FIFO is empty. Bit 6 is 1 when the FIFO is also empty and no frame is on the line.
- R5: A received byte with a valid stop bit enters the receive FIFO, and line status bit 0 is 1 while that FIFO is not empty. A read of offset 0 with line-control bit 7 clear returns the oldest byte and removes it.
- R6: A received frame whose stop bit samples 0 is dropped and sets line status bit 3. That bit clears when offset 5 is read.
- R7: A write to offset 2 empties the receive FIFO if bit 1 is set and the transmit FIFO if bit 2 is set. Its bits 7:6 pick the receive trigger level: 00→1, 01→4, 10→8, 11→14 bytes. A byte already on the line finishes.
- R8: `irq` is 1, one clock after the condition holds, exactly when modem-control bit 3, interrupt-enable bit 0 and a receive level at or above the trigger are all true. Offset 2 reads bit 0 as 0 while `irq` is 1 and as 1 otherwise, with the trigger selection in bits 7:6.
- R9: `dtr` follows modem-control bit 0 and `rts` follows bit 1, both one clock after the write. Offset 4 reads back bits 4:0.
- R10: Offset 7 is a scratch byte that reads back what was last written.
- R11: A byte received while the receive FIFO holds 16 bytes is discarded, and the 16 stored bytes are kept in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one clock per access |
| reg_rd | input | 1 | Read strobe, one clock per access; pops on offset 0 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the strobe cycle |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| dtr | output | 1 | Data-terminal-ready control line |
| rts | output | 1 | Request-to-send control line |
| irq | output | 1 | Receive-level interrupt |

## Verification
Read data is combinational from registered state, so the bench samples `reg_rdata` one nanosecond after the falling edge in the strobe cycle. Register effects on `dtr` and `rts` appear one clock after the write edge and are compared against the model on every falling edge. `irq` lags the FIFO level by one register, so the bench waits several clocks before checking it. A transmitted start bit begins the clock after a sample tick and lasts exactly one bit time, so the bench counts its low falling edges against 16 × divisor × `CLKS_PER_TICK`. Received-data checks run only after line status bit 6 shows the looped-back frame has finished, by which time the mid-stop-bit sample and its two synchronizer stages are long past.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IER  = 3'd1;
    localparam logic [2:0] OFS_FCR  = 3'd2;
    localparam logic [2:0] OFS_LCR  = 3'd3;
    localparam logic [2:0] OFS_MCR  = 3'd4;
    localparam logic [2:0] OFS_LSR  = 3'd5;
    localparam logic [2:0] OFS_MSR  = 3'd6;
    localparam logic [2:0] OFS_SCR  = 3'd7;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAITHI
    } rx_state_e;

    // receive trigger level selected by FIFO-control bits 7:6
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t       s_d, s_q;
    logic [W-1:0]   mem [DEPTH];
    logic           do_push, do_pop;

    always_comb begin
        do_push = push && (s_q.cnt != CW'(DEPTH));
        do_pop  = pop && (s_q.cnt != '0);
        s_d     = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            if (do_push) s_d.wr = s_q.wr + 1'b1;
            if (do_pop)  s_d.rd = s_q.rd + 1'b1;
            s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[s_q.wr] <= wdata;
    end

    assign rdata = mem[s_q.rd];
    assign count = s_q.cnt;

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    // R7
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/uart_tx.sv
module uart_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       have,
    input  logic [7:0] data,
    output logic       pop,
    output logic       busy,
    output logic       txd
);
    typedef struct packed {
        logic       busy;
        logic [3:0] sub;
        logic [3:0] bitn;
        logic [7:0] sh;
    } tx_st_t;

    tx_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        pop = 1'b0;
        if (!s_q.busy) begin
            if (have && tick16) begin
                pop      = 1'b1;
                s_d.busy = 1'b1;
                s_d.sub  = '0;
                s_d.bitn = '0;
                s_d.sh   = data;
            end
        end else if (tick16) begin
            s_d.sub = s_q.sub + 4'd1;
            if (s_q.sub == 4'd15) begin
                if (s_q.bitn == 4'd9) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.bitn = s_q.bitn + 4'd1;
                    if (s_q.bitn != 4'd0) s_d.sh = s_q.sh >> 1;
                end
            end
        end
        if (!s_q.busy)               txd = 1'b1;
        else if (s_q.bitn == 4'd0)   txd = 1'b0;
        else if (s_q.bitn == 4'd9)   txd = 1'b1;
        else                         txd = s_q.sh[0];
        busy = s_q.busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    start_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !txd);

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    output logic       push,
    output logic       ferr,
    output logic [7:0] data
);
    typedef struct packed {
        rx_state_e  st;
        logic [3:0] sub;
        logic [2:0] bitn;
        logic [7:0] sh;
    } rx_st_t;

    rx_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        push = 1'b0;
        ferr = 1'b0;
        unique case (s_q.st)
            RX_IDLE: if (!rxd) begin
                s_d.st  = RX_START;
                s_d.sub = '0;
            end
            RX_START: if (tick16) begin
                s_d.sub = s_q.sub + 4'd1;
                if (s_q.sub == 4'd7) begin
                    s_d.sub  = '0;
                    s_d.bitn = '0;
                    s_d.st   = rxd ? RX_IDLE : RX_DATA;
                end
            end
            RX_DATA: if (tick16) begin
                s_d.sub = s_q.sub + 4'd1;
                if (s_q.sub == 4'd15) begin
                    s_d.sh   = {rxd, s_q.sh[7:1]};
                    s_d.bitn = s_q.bitn + 3'd1;
                    if (s_q.bitn == 3'd7) s_d.st = RX_STOP;
                end
            end
            RX_STOP: if (tick16) begin
                s_d.sub = s_q.sub + 4'd1;
                if (s_q.sub == 4'd15) begin
                    if (rxd) begin
                        push   = 1'b1;
                        s_d.st = RX_IDLE;
                    end else begin
                        ferr   = 1'b1;
                        s_d.st = RX_WAITHI;
                    end
                end
            end
            RX_WAITHI: if (rxd) s_d.st = RX_IDLE;
            default: s_d.st = RX_IDLE;
        endcase
        data = s_q.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: RX_IDLE, sub: '0, bitn: '0, sh: '0};
        else        s_q <= s_d;
    end

endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int          DEPTH         = 16,
    parameter int          CLKS_PER_TICK = 4,
    parameter logic [15:0] DIV_RESET     = 16'd1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       dtr,
    output logic       rts,
    output logic       irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int RW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;

    typedef struct packed {
        logic [7:0]    lcr;
        logic [3:0]    ier;
        logic [4:0]    mcr;
        logic [7:0]    scr;
        logic [7:0]    dll;
        logic [7:0]    dlm;
        logic [1:0]    trig_sel;
        logic          ferr;
        logic          irq;
        logic [RW-1:0] ref_cnt;
        logic [15:0]   div_cnt;
        logic          rxd_s1;
        logic          rxd_s2;
    } regs_t;

    regs_t          s_d, s_q;
    logic           ref_tick, tick16, dlab;
    logic [15:0]    divisor;
    logic [CW-1:0]  rx_cnt, tx_cnt, trig;
    logic [7:0]     rx_head, tx_head, rx_byte;
    logic           tx_push, tx_pop, tx_clr, tx_busy;
    logic           rx_push, rx_pop, rx_clr, rx_ferr, rx_dr, tx_empty;

    assign dlab     = s_q.lcr[7];
    assign divisor  = {s_q.dlm, s_q.dll};
    assign trig     = CW'(trig_level(s_q.trig_sel));
    assign tx_push  = reg_wr && (reg_addr == OFS_DATA) && !dlab;
    assign rx_pop   = reg_rd && (reg_addr == OFS_DATA) && !dlab;
    assign tx_clr   = reg_wr && (reg_addr == OFS_FCR) && reg_wdata[2];
    assign rx_clr   = reg_wr && (reg_addr == OFS_FCR) && reg_wdata[1];
    assign rx_dr    = (rx_cnt != '0);
    assign tx_empty = (tx_cnt == '0);

    always_comb begin
        s_d = s_q;
        ref_tick    = (s_q.ref_cnt == RW'(CLKS_PER_TICK - 1));
        s_d.ref_cnt = ref_tick ? '0 : s_q.ref_cnt + 1'b1;
        tick16      = 1'b0;
        if (ref_tick && (divisor != '0)) begin
            if (s_q.div_cnt >= divisor - 16'd1) begin
                s_d.div_cnt = '0;
                tick16      = 1'b1;
            end else begin
                s_d.div_cnt = s_q.div_cnt + 16'd1;
            end
        end
        s_d.rxd_s1 = rxd;
        s_d.rxd_s2 = s_q.rxd_s1;
        if (reg_wr) begin
            unique case (reg_addr)
                OFS_DATA: if (dlab) s_d.dll = reg_wdata;
                OFS_IER:  if (dlab) s_d.dlm = reg_wdata; else s_d.ier = reg_wdata[3:0];
                OFS_FCR:  s_d.trig_sel = reg_wdata[7:6];
                OFS_LCR:  s_d.lcr = reg_wdata;
                OFS_MCR:  s_d.mcr = reg_wdata[4:0];
                OFS_SCR:  s_d.scr = reg_wdata;
                default: ;
            endcase
        end
        if (reg_rd && (reg_addr == OFS_LSR)) s_d.ferr = 1'b0;
        if (rx_ferr) s_d.ferr = 1'b1;
        s_d.irq = s_q.mcr[3] && s_q.ier[0] && (rx_cnt >= trig);

        unique case (reg_addr)
            OFS_DATA: reg_rdata = dlab ? s_q.dll : (rx_dr ? rx_head : 8'h00);
            OFS_IER:  reg_rdata = dlab ? s_q.dlm : {4'h0, s_q.ier};
            OFS_FCR:  reg_rdata = {s_q.trig_sel, 5'b0, !s_q.irq};
            OFS_LCR:  reg_rdata = s_q.lcr;
            OFS_MCR:  reg_rdata = {3'b0, s_q.mcr};
            OFS_LSR:  reg_rdata = {1'b0, tx_empty && !tx_busy, tx_empty, 1'b0,
                                   s_q.ferr, 2'b0, rx_dr};
            OFS_MSR:  reg_rdata = 8'h00;
            default:  reg_rdata = s_q.scr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.dll     <= DIV_RESET[7:0];
            s_q.dlm     <= DIV_RESET[15:8];
            s_q.rxd_s1  <= 1'b1;
            s_q.rxd_s2  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign dtr = s_q.mcr[0];
    assign rts = s_q.mcr[1];
    assign irq = s_q.irq;

    uart_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt)
    );

    uart_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head), .count(rx_cnt)
    );

    uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .have(!tx_empty), .data(tx_head),
        .pop(tx_pop), .busy(tx_busy), .txd(txd)
    );

    uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(s_q.rxd_s2),
        .push(rx_push), .ferr(rx_ferr), .data(rx_byte)
    );

    // R2
    latch_write_no_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_DATA && dlab && !tx_pop && !tx_clr)
            |=> (tx_cnt == $past(tx_cnt)));

    // R6
    bad_stop_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ferr && !rx_pop && !rx_clr) |=> (rx_cnt == $past(rx_cnt)));

    // R6
    lsr_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_LSR && !rx_ferr) |=> !s_q.ferr);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.mcr[3] || rx_cnt < trig) |=> !irq);

    // R3
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !tx_busy) |-> txd);

endmodule

// File: tb/uart_regif_tb_top.sv
`timescale 1ns/1ps
module uart_regif_tb_top;
    localparam int CLKS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rxd, txd, dtr, rts, irq;
    logic       loop_en = 1'b0;
    logic       bench_rxd = 1'b1;

    assign rxd = loop_en ? txd : bench_rxd;

    always #2 clk = ~clk;

    uart_regif #(.DEPTH(16), .CLKS_PER_TICK(CLKS), .DIV_RESET(16'd1)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd),
        .dtr(dtr), .rts(rts), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [7:0] m_lcr = '0;
    logic [7:0] m_mcr = '0;
    int         m_div = 1;
    byte unsigned tx_exp[$];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1;
        if (a == 3'd3) m_lcr = d;
        if (a == 3'd4) m_mcr = d;
        if (a == 3'd0 && m_lcr[7]) m_div = (m_div & 32'hFF00) | int'(d);
        if (a == 3'd1 && m_lcr[7]) m_div = (m_div & 32'h00FF) | (int'(d) << 8);
        if (a == 3'd0 && !m_lcr[7]) tx_exp.push_back(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        check(req, int'(v), int'(exp));
    endtask

    task automatic wait_tx_idle();
        logic [7:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd5, v);
            if (v[6]) break;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        int bp;
        bp = 16 * m_div * CLKS;
        @(negedge clk);
        bench_rxd = 1'b0;
        repeat (bp) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            bench_rxd = b[i];
            repeat (bp) @(negedge clk);
        end
        bench_rxd = stop;
        repeat (bp) @(negedge clk);
        bench_rxd = 1'b1;
        repeat (bp) @(negedge clk);
    endtask

    // R9: modem-control lines compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 dtr", int'(dtr), int'(m_mcr[0]));
            check("R9 rts", int'(rts), int'(m_mcr[1]));
        end
    end

    // R3: line monitor decodes every frame on txd at mid-bit
    initial begin
        forever begin
            int bp;
            logic [7:0] b;
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                bp = 16 * m_div * CLKS;
                repeat (bp / 2 - 1) @(negedge clk);
                check("R3 start bit", int'(txd), 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (bp) @(negedge clk);
                    b[i] = txd;
                end
                repeat (bp) @(negedge clk);
                check("R3 stop bit", int'(txd), 1);
                if (tx_exp.size() == 0) check("R3 unexpected frame", int'(b), -1);
                else check("R3 frame data", int'(b), int'(tx_exp.pop_front()));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        report();
    end

    initial begin
        int cnt;
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 txd", int'(txd), 1);
        check("R1 irq", int'(irq), 0);
        rd_chk(3'd5, 8'h60, "R1 lsr");
        rd_chk(3'd3, 8'h00, "R1 lcr");
        rd_chk(3'd1, 8'h00, "R1 ier");
        rd_chk(3'd4, 8'h00, "R1 mcr");
        rd_chk(3'd7, 8'h00, "R1 scratch");

        // R2 divisor latch overlay
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h80);
        rd_chk(3'd0, 8'h01, "R1 divisor low");
        rd_chk(3'd1, 8'h00, "R1 divisor high");
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h00);
        rd_chk(3'd0, 8'h03, "R2 divisor low");
        rd_chk(3'd1, 8'h00, "R2 divisor high");
        rd_chk(3'd5, 8'h60, "R2 no queued byte");
        wr(3'd3, 8'h03);
        rd_chk(3'd3, 8'h03, "R2 lcr readback");
        wr(3'd1, 8'h0D);
        rd_chk(3'd1, 8'h0D, "R2 ier via offset 1");
        wr(3'd3, 8'h80);
        rd_chk(3'd0, 8'h03, "R2 divisor kept");
        wr(3'd3, 8'h03);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'hC7);
        wr(3'd4, 8'h0B);
        rd_chk(3'd4, 8'h0B, "R9 mcr readback");

        // R10 scratch
        wr(3'd7, 8'h3C);
        rd_chk(3'd7, 8'h3C, "R10 scratch");

        // R3 bit time at divisor 3
        wr(3'd0, 8'hA5);
        while (txd !== 1'b0) @(negedge clk);
        cnt = 0;
        while (txd === 1'b0) begin cnt++; @(negedge clk); end
        check("R3 bit time div3", cnt, 16 * 3 * CLKS);
        wait_tx_idle();
        rd_chk(3'd5, 8'h60, "R4 idle after send");

        // R3 bit time at divisor 1
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h01);
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h55);
        while (txd !== 1'b0) @(negedge clk);
        cnt = 0;
        while (txd === 1'b0) begin cnt++; @(negedge clk); end
        check("R3 bit time div1", cnt, 16 * CLKS);
        wait_tx_idle();

        // R8 / R7 trigger 4 in loopback
        loop_en = 1'b1;
        wr(3'd1, 8'h01);
        wr(3'd2, 8'h47);
        for (int i = 0; i < 3; i++) wr(3'd0, 8'(8'h20 + i));
        wait_tx_idle();
        check("R8 below trigger 4", int'(irq), 0);
        rd_chk(3'd5, 8'h61, "R5 data ready");
        wr(3'd0, 8'h23);
        wait_tx_idle();
        check("R8 at trigger 4", int'(irq), 1);
        rd_chk(3'd2, 8'h40, "R8 pending in offset 2");
        wr(3'd4, 8'h03);
        repeat (2) @(negedge clk);
        check("R8 gated by mcr bit 3", int'(irq), 0);
        wr(3'd4, 8'h0B);
        repeat (2) @(negedge clk);
        check("R8 regated", int'(irq), 1);
        for (int i = 0; i < 4; i++) rd_chk(3'd0, 8'(8'h20 + i), "R5 rx order");
        repeat (2) @(negedge clk);
        check("R8 cleared after reads", int'(irq), 0);
        rd_chk(3'd5, 8'h60, "R5 rx empty");

        // R7 trigger 14 and R11 overflow
        wr(3'd2, 8'hC7);
        for (int i = 0; i < 13; i++) wr(3'd0, 8'(8'h40 + i));
        wait_tx_idle();
        check("R7 below trigger 14", int'(irq), 0);
        wr(3'd0, 8'h4D);
        wait_tx_idle();
        check("R7 at trigger 14", int'(irq), 1);
        for (int i = 14; i < 17; i++) wr(3'd0, 8'(8'h40 + i));
        wait_tx_idle();
        for (int i = 0; i < 16; i++) rd_chk(3'd0, 8'(8'h40 + i), "R11 kept bytes");
        rd_chk(3'd5, 8'h60, "R11 extra byte dropped");

        // R7 receive clear
        wr(3'd0, 8'h77);
        wr(3'd0, 8'h78);
        wait_tx_idle();
        rd_chk(3'd5, 8'h61, "R7 rx before clear");
        wr(3'd2, 8'hC3);
        rd_chk(3'd5, 8'h60, "R7 rx cleared");

        // R7 / R4 transmit clear
        loop_en = 1'b0;
        for (int i = 0; i < 5; i++) wr(3'd0, 8'(8'h90 + i));
        while (txd !== 1'b0) @(negedge clk);
        wr(3'd2, 8'hC5);
        repeat (4) void'(tx_exp.pop_back());
        rd_chk(3'd5, 8'h20, "R4 tx fifo empty while shifting");
        wait_tx_idle();
        check("R7 only running byte sent", tx_exp.size(), 0);

        // R6 framing error
        send_rx(8'h81, 1'b0);
        rd_chk(3'd5, 8'h68, "R6 framing error set, byte dropped");
        rd_chk(3'd5, 8'h60, "R6 cleared by read");
        send_rx(8'h3E, 1'b1);
        rd_chk(3'd5, 8'h61, "R5 good byte after error");
        rd_chk(3'd0, 8'h3E, "R5 good byte value");
        rd_chk(3'd5, 8'h60, "R5 popped");

        repeat (20) @(negedge clk);
        check("R3 all frames seen", tx_exp.size(), 0);
        done = 1'b1;
        report();
    end

endmodule